// File: doc/BRIEF.md
# Borrow-Input Column Compressor Cell

This cell compresses one column of a partial-product reduction tree. It takes four operand bits of weight 1 and one borrow bit of weight 2. It returns three output bits whose weighted sum equals the weighted sum of its inputs. The inputs can total anything from 0 to 6, so the result appears as a weight-1 sum bit, a weight-2 carry and a weight-4 carry. A multiplier array places one cell per column and routes the two carries to the columns one and two places higher.

Inside the cell, partial values travel as 4-line one-hot codes, where exactly one line is high and line k means the integer k. Two input pairs are each encoded into such a code:

- The borrow bit and one operand bit form the value 0..3.
- Two further operand bits form the value 0..2.

A one-hot adder then combines both codes with the last operand bit, which has the same weight, without converting anything to binary first. The adder gives a one-hot residue modulo 4 and a weight-4 carry. A small decoder turns the residue into the binary sum bit and the weight-2 carry.

The cell is purely combinational. Its outputs follow its inputs with no clock.

Top module: `borrow_counter_cell`

## Requirements
- R1: With every input low, all three outputs are low.
- R2: For all 32 input combinations, sum_o + 2*carry_o + 4*carry_hi_o equals the number of set bits in data_i plus 2*borrow_i. Bits 0..3 of data_i each weigh 1, and borrow_i weighs 2.
- R3: The two first-stage codes each have exactly one of their four lines high for any input. Line k high means the value k.
- R4: The embedded adder's residue code has exactly one line high. Its carry is high exactly when the sum of the two code values and the binary bit is 4 or more.
- R5: sum_o equals bit 0 (the parity) of the weighted input total.
- R6: carry_o equals bit 1 of the weighted input total.
- R7: carry_hi_o is high exactly when the weighted input total is 4 or more. At the maximum input (all five bits set, total 6), the outputs are sum_o=0, carry_o=1 and carry_hi_o=1.
- R8: The outputs depend only on the current inputs: the same input vector gives the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 4 | Operand bits, each of weight 1 |
| borrow_i | input | 1 | Borrow bit of weight 2 |
| sum_o | output | 1 | Result bit of weight 1 |
| carry_o | output | 1 | Carry of weight 2, to the next column |
| carry_hi_o | output | 1 | Carry of weight 4, to the column two places up |

## Verification
Assertions placed in the RTL check three things whenever the inputs settle:

- the one-hot property of both first-stage codes and of the adder residue;
- the adder carry against the code values it adds;
- conservation of the weighted total across the cell.

Only the bench's scenarios show the individual bit meanings of the outputs, the all-zero and all-ones corners, and that the result does not depend on input history. The bench covers history by applying the full input space in ascending order and again in a scrambled order.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int unsigned OH_W     = 4;  // one-hot lines, values 0..OH_W-1
  localparam int unsigned NUM_UNIT = 4;  // weight-1 operand bits
  localparam int unsigned OH_IDX_W = $clog2(OH_W);
  typedef logic [OH_W-1:0] oh_t;
endpackage

// File: rtl/bpc_oh_encode.sv
module bpc_oh_encode
  import bpc_pkg::*;
#(
  parameter int unsigned HI_WEIGHT = 1
) (
  input  logic lo_i,
  input  logic hi_i,
  output oh_t  oh_o
);
  localparam int unsigned NUM_COMBO = 4;

  if (HI_WEIGHT < 1 || HI_WEIGHT > 2) begin : g_bad_weight
    initial $error("bpc_oh_encode: HI_WEIGHT must be 1 or 2");
  end

  // Map the two-bit pair straight onto a value line.
  always_comb begin
    oh_o = '0;
    for (int unsigned idx = 0; idx < NUM_COMBO; idx++) begin
      if ({hi_i, lo_i} == 2'(idx))
        oh_o[(idx % 2) + HI_WEIGHT * (idx / 2)] = 1'b1;
    end
  end

  always_comb begin
    if (!$isunknown({hi_i, lo_i}))
      AST_ENC_ONEHOT: assert ($onehot(oh_o)) else $error("encoder code not one-hot"); // R3
  end
endmodule

// File: rtl/bpc_oh_adder.sv
module bpc_oh_adder
  import bpc_pkg::*;
(
  input  oh_t  x_i,
  input  oh_t  y_i,
  input  logic c_i,
  output oh_t  res_o,
  output logic carry_o
);
  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    for (int unsigned i = 0; i < OH_W; i++) begin
      for (int unsigned j = 0; j < OH_W; j++) begin
        if (x_i[i] && y_i[j]) begin
          res_o[(i + j + 32'(c_i)) % OH_W] = 1'b1;
          if (i + j + 32'(c_i) >= OH_W) carry_o = 1'b1;
        end
      end
    end
  end

  // Independent value view of the codes, used only by the checks.
  logic [OH_IDX_W:0] x_val, y_val;
  always_comb begin
    x_val = '0;
    y_val = '0;
    for (int unsigned k = 0; k < OH_W; k++) begin
      if (x_i[k]) x_val = (OH_IDX_W+1)'(k);
      if (y_i[k]) y_val = (OH_IDX_W+1)'(k);
    end
  end

  always_comb begin
    if (!$isunknown({x_i, y_i, c_i}) && $onehot(x_i) && $onehot(y_i)) begin
      AST_RES_ONEHOT: assert ($onehot(res_o)) else $error("adder residue not one-hot"); // R4
      AST_CARRY_RANGE: assert (carry_o == ((x_val + y_val + 32'(c_i)) >= OH_W))
        else $error("adder carry mismatch"); // R4
    end
  end
endmodule

// File: rtl/bpc_oh_decode.sv
module bpc_oh_decode
  import bpc_pkg::*;
(
  input  oh_t  res_i,
  input  logic carry_i,
  output logic bit0_o,
  output logic bit1_o,
  output logic bit2_o
);
  always_comb begin
    bit0_o = 1'b0;
    bit1_o = 1'b0;
    for (int unsigned k = 0; k < OH_W; k++) begin
      if (res_i[k]) begin
        bit0_o = bit0_o | k[0];
        bit1_o = bit1_o | k[1];
      end
    end
    bit2_o = carry_i;
  end
endmodule

// File: rtl/borrow_counter_cell.sv
module borrow_counter_cell
  import bpc_pkg::*;
(
  input  logic [NUM_UNIT-1:0] data_i,
  input  logic                borrow_i,
  output logic                sum_o,
  output logic                carry_o,
  output logic                carry_hi_o
);
  oh_t  oh_b, oh_p, oh_res;
  logic add_carry;

  // Borrow pairs with data_i[0]: value 0..3.
  bpc_oh_encode #(.HI_WEIGHT(2)) u_enc_b (
    .lo_i (data_i[0]),
    .hi_i (borrow_i),
    .oh_o (oh_b)
  );

  // data_i[1] + data_i[2]: value 0..2.
  bpc_oh_encode #(.HI_WEIGHT(1)) u_enc_p (
    .lo_i (data_i[1]),
    .hi_i (data_i[2]),
    .oh_o (oh_p)
  );

  // data_i[3] enters as the same-weight binary bit.
  bpc_oh_adder u_add (
    .x_i     (oh_b),
    .y_i     (oh_p),
    .c_i     (data_i[3]),
    .res_o   (oh_res),
    .carry_o (add_carry)
  );

  bpc_oh_decode u_dec (
    .res_i   (oh_res),
    .carry_i (add_carry),
    .bit0_o  (sum_o),
    .bit1_o  (carry_o),
    .bit2_o  (carry_hi_o)
  );

  logic [2:0] in_total, out_total;
  always_comb begin
    in_total = {1'b0, borrow_i, 1'b0};
    for (int unsigned n = 0; n < NUM_UNIT; n++) in_total = in_total + 3'(data_i[n]);
    out_total = {carry_hi_o, carry_o, sum_o};
  end

  always_comb begin
    if (!$isunknown({data_i, borrow_i})) begin
      AST_SUM_CONSERVED: assert (out_total == in_total) else $error("weighted sum not conserved"); // R2
      AST_ZERO_IN_ZERO_OUT: assert (in_total != 3'd0 || out_total == 3'd0)
        else $error("nonzero output for zero input"); // R1
    end
  end
endmodule

// File: tb/tb_borrow_counter_cell.sv
module tb_borrow_counter_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] data;
  logic       borrow;
  logic       sum_w, carry_w, carry_hi_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [4:0] stim;
    int         total;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  borrow_counter_cell dut (
    .data_i     (data),
    .borrow_i   (borrow),
    .sum_o      (sum_w),
    .carry_o    (carry_w),
    .carry_hi_o (carry_hi_w)
  );

  task automatic check(input string req, input int act, input int expv, input logic [4:0] stim);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s stim=%b actual=%0d expected=%0d", req, stim, act, expv);
    end
  endtask

  task automatic drive(input logic [4:0] v);
    @(posedge clk);
    #1;
    borrow = v[4];
    data   = v[3:0];
    exp_q.push_back('{stim: v, total: int'($countones(v[3:0])) + 2 * int'(v[4])});
  endtask

  // Monitor: samples at the falling edge, after the drive has settled.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R2", int'(sum_w) + 2 * int'(carry_w) + 4 * int'(carry_hi_w), e.total, e.stim);
      check("R5", int'(sum_w), e.total % 2, e.stim);
      check("R6", int'(carry_w), (e.total / 2) % 2, e.stim);
      check("R7", int'(carry_hi_w), (e.total >= 4) ? 1 : 0, e.stim);
      if (e.stim == 5'h1f) check("R7", {29'd0, carry_hi_w, carry_w, sum_w}, 6, e.stim);
    end
  end

  initial begin
    data   = '0;
    borrow = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {29'd0, carry_hi_w, carry_w, sum_w}, 0, 5'd0);
    rst_n = 1'b1;
    // Full space, ascending.
    for (int v = 0; v < 32; v++) drive(5'(v));
    // R8: scrambled order revisits every vector after different predecessors.
    for (int v = 0; v < 32; v++) drive(5'((v * 13 + 7) % 32));
    drive(5'h1f);
    drive(5'h00);  // R1 after a maximal input
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) check("R2", exp_q.size(), 0, 5'd0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule